// File: doc/BRIEF.md
# Dual Output Compare Channel with Combined Reference

This block holds two output compare channels that watch one shared timer count and one shared count direction. Each channel keeps a configuration word, a shadow compare value and an active compare value. From the count, the active compare value and the selected mode, each channel drives a reference level. A third output merges the two references according to the mode of channel 0. The timer counter itself, capture logic, dead-time, polarity and pin enables belong to neighbouring blocks.

Software reaches the block through a write-only port. `wr_addr[1]` picks the channel and `wr_addr[0]` picks the word: 0 is the configuration, 1 is the compare value. The configuration word has these fields:

- bits 1:0 are the channel select, and only 0 means output use;
- bit 2 is the fast-enable flag;
- bit 3 enables preload;
- bits 6:4 are the low three bits of a 4-bit mode code;
- bit 16 is the top bit of the mode code.

The counter value, the direction, the trigger strobe and the update strobe first pass through a one-cycle input register. Each channel's reference is the output of a four-state machine:

- **States**: `REF_LOW` and `REF_HIGH` are the free-running levels. `HELD_LOW` and `HELD_HIGH` are the levels latched by a trigger in the one-pulse modes.
- **Transitions**:
  - *match set/clear/toggle* happens on compare equality.
  - *force* moves to a fixed level.
  - *pwm compare* picks the level from the counter-versus-compare test.
  - *trigger hold* enters a held state.
  - *update release* leaves a held state on an update strobe.
  - *keep* leaves the level unchanged. It applies in the frozen and reserved codes and when the select field is non-zero.
  - A held state seen under a mode that is not one-pulse falls back to the plain state of the same level.

Top module: `ocp_pair_top`

## Requirements
- R1: After reset, every configuration field and compare value is zero, and `ref_out` and `comb_out` are low.
- R2: Mode codes 0, 10 and 11 keep the channel reference at its present level, whatever the counter does.
- R3: A counter value sampled at one clock edge affects the reference at the next edge. Code 1 sets the reference on equality, code 2 clears it on equality, and code 3 inverts it on every cycle in which the registered count equals the compare value.
- R4: Code 4 drives the reference low and code 5 drives it high, whatever the counter value.
- R5: In code 6 with `cnt_down`=0, the reference is high when count < compare. With `cnt_down`=1, it is high when count <= compare. Code 7 gives the complement of code 6.
- R6: In code 8 with no trigger pending, the reference is high while counting up and low while counting down. A trigger strobe holds it low until the next update strobe. If both strobes come in the same cycle, the trigger wins. Code 9 is the complement of code 8.
- R7: Codes 12 and 13 give a channel the references of codes 6 and 7. When channel 0 uses code 12, `comb_out` is the OR of both references; when it uses code 13, `comb_out` is their AND. Under any mode of channel 0 outside 12 to 15, `comb_out` follows channel 0's reference.
- R8: Codes 14 and 15 give a channel the references of codes 6 and 7. When channel 0 uses one of them, `comb_out` follows channel 0's reference while counting up and channel 1's reference while counting down.
- R9: With preload off (bit 3 = 0), a compare write reaches the active value at once. With preload on, the write goes only to the shadow value, and an update strobe copies the shadow into the active value.
- R10: A non-zero select field (bits 1:0) makes the channel keep its level, whatever the mode. The fast-enable bit (bit 2) has no effect on the reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_in | input | CNT_W | Shared timer count |
| cnt_down | input | 1 | 1 = counter is counting down |
| upd_evt | input | 1 | Update strobe, one cycle |
| trig_evt | input | 1 | Trigger strobe, one cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Bit 1 is the channel; bit 0 selects configuration (0) or compare (1) |
| wr_data | input | 32 | Write data |
| ref_out | output | 2 | Per-channel reference levels |
| comb_out | output | 1 | Combined reference |

## Verification
A wrong machine state shows directly at `ref_out` two edges after the count that caused it. A missed entry into a held state shows up as a reference that stays high after a trigger. A held state that is never released stays low through an update strobe and stays wrong until reset. A mis-loaded active compare value is not visible by itself: it only moves the PWM edge. For that reason, the bench places the count between the shadow and active values, so a premature or missing copy flips the reference in the first settled cycle.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    localparam int NCH    = 2;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 32;

    // configuration word bit positions
    localparam int SEL_LSB   = 0;
    localparam int PRE_BIT   = 3;
    localparam int MODE_LSB  = 4;
    localparam int MODE_TOP  = 16;

    typedef enum logic [3:0] {
        OCM_FROZEN  = 4'd0,
        OCM_SET     = 4'd1,
        OCM_CLR     = 4'd2,
        OCM_TOG     = 4'd3,
        OCM_LOW     = 4'd4,
        OCM_HIGH    = 4'd5,
        OCM_PWM_A   = 4'd6,
        OCM_PWM_B   = 4'd7,
        OCM_OPM_A   = 4'd8,
        OCM_OPM_B   = 4'd9,
        OCM_RSV_A   = 4'd10,
        OCM_RSV_B   = 4'd11,
        OCM_CMB_OR  = 4'd12,
        OCM_CMB_AND = 4'd13,
        OCM_ASY_A   = 4'd14,
        OCM_ASY_B   = 4'd15
    } ocm_e;

    typedef struct packed {
        logic [1:0] sel;
        logic       pre;
        ocm_e       mode;
    } chcfg_t;

    typedef enum logic [1:0] {
        REF_LOW   = 2'd0,
        REF_HIGH  = 2'd1,
        HELD_LOW  = 2'd2,
        HELD_HIGH = 2'd3
    } ref_st_e;

    function automatic chcfg_t decode_cfg(input logic [DATA_W-1:0] w);
        chcfg_t c;
        c.sel  = w[SEL_LSB +: 2];
        c.pre  = w[PRE_BIT];
        c.mode = ocm_e'({w[MODE_TOP], w[MODE_LSB +: 3]});
        return c;
    endfunction

endpackage

// File: rtl/ocp_input_stage.sv
module ocp_input_stage #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             cnt_down,
    input  logic             upd_evt,
    input  logic             trig_evt,
    output logic [CNT_W-1:0] cnt_q,
    output logic             dir_q,
    output logic             upd_q,
    output logic             trig_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            dir_q  <= 1'b0;
            upd_q  <= 1'b0;
            trig_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_in;
            dir_q  <= cnt_down;
            upd_q  <= upd_evt;
            trig_q <= trig_evt;
        end
    end

endmodule

// File: rtl/ocp_chan_regs.sv
module ocp_chan_regs
    import ocp_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int CH_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              upd_evt,
    output chcfg_t            cfg_o,
    output logic [CNT_W-1:0]  cmp_o
);

    logic             cfg_hit;
    logic             cmp_hit;
    logic [CNT_W-1:0] shadow_q;
    logic [CNT_W-1:0] shadow_nxt;
    logic             unused_wr;

    // fast-enable and spare bits are accepted and dropped
    assign unused_wr  = ^wr_data;

    assign cfg_hit    = wr_en && (wr_addr[1] == CH_ID[0]) && !wr_addr[0];
    assign cmp_hit    = wr_en && (wr_addr[1] == CH_ID[0]) &&  wr_addr[0];
    assign shadow_nxt = cmp_hit ? wr_data[CNT_W-1:0] : shadow_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_o    <= '0;
            shadow_q <= '0;
            cmp_o    <= '0;
        end else begin
            if (cfg_hit) begin
                cfg_o <= decode_cfg(wr_data);
            end
            shadow_q <= shadow_nxt;
            if (cmp_hit && !cfg_o.pre) begin
                cmp_o <= wr_data[CNT_W-1:0];
            end else if (upd_evt) begin
                cmp_o <= shadow_nxt;
            end
        end
    end

endmodule

// File: rtl/ocp_ref_fsm.sv
module ocp_ref_fsm
    import ocp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sel,
    input  ocm_e             mode,
    input  logic [CNT_W-1:0] cmp,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             dir_q,
    input  logic             trig_q,
    input  logic             upd_q,
    output logic             ref_o
);

    ref_st_e st_q;
    ref_st_e st_nxt;
    ref_st_e keep;
    ref_st_e pwm_st;
    logic    lvl;
    logic    held;
    logic    hit;
    logic    pwm_a;

    always_comb begin
        lvl    = (st_q == REF_HIGH) || (st_q == HELD_HIGH);
        held   = (st_q == HELD_LOW) || (st_q == HELD_HIGH);
        hit    = (cnt_q == cmp);
        pwm_a  = dir_q ? (cnt_q <= cmp) : (cnt_q < cmp);
        keep   = lvl ? REF_HIGH : REF_LOW;
        pwm_st = pwm_a ? REF_HIGH : REF_LOW;
        st_nxt = keep;
        if (sel == 2'b00) begin
            unique case (mode)
                OCM_SET:  st_nxt = hit ? REF_HIGH : keep;
                OCM_CLR:  st_nxt = hit ? REF_LOW : keep;
                OCM_TOG:  st_nxt = hit ? (lvl ? REF_LOW : REF_HIGH) : keep;
                OCM_LOW:  st_nxt = REF_LOW;
                OCM_HIGH: st_nxt = REF_HIGH;
                OCM_PWM_A, OCM_CMB_OR, OCM_ASY_A:
                    st_nxt = pwm_st;
                OCM_PWM_B, OCM_CMB_AND, OCM_ASY_B:
                    st_nxt = pwm_a ? REF_LOW : REF_HIGH;
                OCM_OPM_A: begin
                    if (trig_q)             st_nxt = HELD_LOW;
                    else if (held && !upd_q) st_nxt = st_q;
                    else                    st_nxt = dir_q ? REF_LOW : REF_HIGH;
                end
                OCM_OPM_B: begin
                    if (trig_q)             st_nxt = HELD_HIGH;
                    else if (held && !upd_q) st_nxt = st_q;
                    else                    st_nxt = dir_q ? REF_HIGH : REF_LOW;
                end
                default:  st_nxt = keep;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= REF_LOW;
        else        st_q <= st_nxt;
    end

    always_comb begin
        ref_o = (st_q == REF_HIGH) || (st_q == HELD_HIGH);
    end

endmodule

// File: rtl/ocp_combiner.sv
module ocp_combiner
    import ocp_pkg::*;
(
    input  ocm_e       mode0,
    input  logic [1:0] refs,
    input  logic       dir_q,
    output logic       comb_o
);

    always_comb begin
        unique case (mode0)
            OCM_CMB_OR:           comb_o = refs[0] | refs[1];
            OCM_CMB_AND:          comb_o = refs[0] & refs[1];
            OCM_ASY_A, OCM_ASY_B: comb_o = dir_q ? refs[1] : refs[0];
            default:              comb_o = refs[0];
        endcase
    end

endmodule

// File: rtl/ocp_pair_top.sv
module ocp_pair_top
    import ocp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              cnt_down,
    input  logic              upd_evt,
    input  logic              trig_evt,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [31:0]       wr_data,
    output logic [1:0]        ref_out,
    output logic              comb_out
);

    logic [CNT_W-1:0] cnt_q;
    logic             dir_q;
    logic             upd_q;
    logic             trig_q;
    chcfg_t           cfg_q [NCH];
    logic [CNT_W-1:0] cmp_q [NCH];
    logic [NCH-1:0]   ref_w;
    logic [3:0]       mode0_w;
    logic [1:0]       sel0_w;

    ocp_input_stage #(.CNT_W(CNT_W)) u_in (
        .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .cnt_down(cnt_down),
        .upd_evt(upd_evt), .trig_evt(trig_evt),
        .cnt_q(cnt_q), .dir_q(dir_q), .upd_q(upd_q), .trig_q(trig_q)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ocp_chan_regs #(.CNT_W(CNT_W), .CH_ID(c)) u_regs (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
            .wr_data(wr_data), .upd_evt(upd_evt),
            .cfg_o(cfg_q[c]), .cmp_o(cmp_q[c])
        );
        ocp_ref_fsm #(.CNT_W(CNT_W)) u_fsm (
            .clk(clk), .rst_n(rst_n), .sel(cfg_q[c].sel), .mode(cfg_q[c].mode),
            .cmp(cmp_q[c]), .cnt_q(cnt_q), .dir_q(dir_q),
            .trig_q(trig_q), .upd_q(upd_q), .ref_o(ref_w[c])
        );
    end

    ocp_combiner u_comb (
        .mode0(cfg_q[0].mode), .refs(ref_w), .dir_q(dir_q), .comb_o(comb_out)
    );

    assign ref_out = ref_w;
    assign mode0_w = cfg_q[0].mode;
    assign sel0_w  = cfg_q[0].sel;

endmodule

// File: rtl/ocp_pair_chk.sv
module ocp_pair_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] ref_out,
    input logic       comb_out,
    input logic [3:0] mode0,
    input logic [1:0] sel0,
    input logic       dir_q
);

    a_r1_low_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ref_out == 2'b00 && !comb_out));

    a_r2_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode0 == 4'd0 && sel0 == 2'b00) |=> $stable(ref_out[0]));

    a_r4_force_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode0 == 4'd4 && sel0 == 2'b00) |=> !ref_out[0]);

    a_r4_force_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mode0 == 4'd5 && sel0 == 2'b00) |=> ref_out[0]);

    a_r7_or_any_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mode0 == 4'd12 && ref_out != 2'b00) |-> comb_out);

    a_r7_and_any_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode0 == 4'd13 && ref_out != 2'b11) |-> !comb_out);

    a_r8_asym_up_ch0: assert property (@(posedge clk) disable iff (!rst_n)
        (mode0 == 4'd14 && !dir_q) |-> (comb_out == ref_out[0]));

    a_r10_sel_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sel0 != 2'b00) |=> $stable(ref_out[0]));

endmodule

bind ocp_pair_top ocp_pair_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ref_out(ref_out), .comb_out(comb_out),
    .mode0(mode0_w), .sel0(sel0_w), .dir_q(dir_q)
);

// File: tb/tb_ocp_pair_top.sv
module tb_ocp_pair_top;

    localparam int CNT_W = 16;
    localparam int WD    = 20000;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [CNT_W-1:0] cnt_in;
    logic             cnt_down;
    logic             upd_evt;
    logic             trig_evt;
    logic             wr_en;
    logic [1:0]       wr_addr;
    logic [31:0]      wr_data;
    logic [1:0]       ref_out;
    logic             comb_out;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    ocp_pair_top #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .cnt_down(cnt_down),
        .upd_evt(upd_evt), .trig_evt(trig_evt), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .ref_out(ref_out), .comb_out(comb_out)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_cnt(input int v, input logic dn);
        cnt_in = CNT_W'(v); cnt_down = dn;
        settle();
    endtask

    task automatic blip_cnt(input int v, input int after);
        cnt_in = CNT_W'(v);
        @(negedge clk);
        cnt_in = CNT_W'(after);
        settle();
    endtask

    task automatic strobe_trig();
        trig_evt = 1'b1; @(negedge clk); trig_evt = 1'b0; settle();
    endtask

    task automatic strobe_upd();
        upd_evt = 1'b1; @(negedge clk); upd_evt = 1'b0; settle();
    endtask

    task automatic t_reset();
        chk("R1", "ref0 after reset", ref_out[0], 1'b0);
        chk("R1", "ref1 after reset", ref_out[1], 1'b0);
        chk("R1", "comb after reset", comb_out, 1'b0);
    endtask

    task automatic t_force();
        wr(2'b00, 32'h50); wr(2'b10, 32'h40); set_cnt(7, 1'b0);
        chk("R4", "ch0 code 5 high", ref_out[0], 1'b1);
        chk("R4", "ch1 code 4 low", ref_out[1], 1'b0);
        set_cnt(900, 1'b1);
        chk("R4", "ch0 high any count", ref_out[0], 1'b1);
        chk("R7", "comb follows ch0 by default", comb_out, 1'b1);
    endtask

    task automatic t_frozen();
        wr(2'b00, 32'h0); set_cnt(3, 1'b0);
        chk("R2", "code 0 keeps high", ref_out[0], 1'b1);
        wr(2'b00, 32'h10020); set_cnt(0, 1'b0);
        chk("R2", "code 10 keeps high", ref_out[0], 1'b1);
        wr(2'b00, 32'h40); settle();
        wr(2'b00, 32'h10030); set_cnt(5, 1'b0);
        chk("R2", "code 11 keeps low", ref_out[0], 1'b0);
    endtask

    task automatic t_match();
        wr(2'b00, 32'h40); wr(2'b01, 32'd100); wr(2'b00, 32'h10); set_cnt(50, 1'b0);
        chk("R3", "code 1 no match", ref_out[0], 1'b0);
        set_cnt(100, 1'b0);
        chk("R3", "code 1 sets on match", ref_out[0], 1'b1);
        set_cnt(50, 1'b0);
        chk("R3", "code 1 stays set", ref_out[0], 1'b1);
        wr(2'b00, 32'h20); settle();
        chk("R3", "code 2 no match", ref_out[0], 1'b1);
        set_cnt(100, 1'b0);
        chk("R3", "code 2 clears on match", ref_out[0], 1'b0);
        set_cnt(101, 1'b0);
        wr(2'b00, 32'h30); settle();
        chk("R3", "code 3 no match", ref_out[0], 1'b0);
        blip_cnt(100, 101);
        chk("R3", "code 3 single toggle up", ref_out[0], 1'b1);
        blip_cnt(100, 101);
        chk("R3", "code 3 single toggle down", ref_out[0], 1'b0);
    endtask

    task automatic t_pwm();
        wr(2'b00, 32'h60); set_cnt(99, 1'b0);
        chk("R5", "code 6 up below", ref_out[0], 1'b1);
        set_cnt(100, 1'b0);
        chk("R5", "code 6 up equal", ref_out[0], 1'b0);
        set_cnt(100, 1'b1);
        chk("R5", "code 6 down equal", ref_out[0], 1'b1);
        set_cnt(101, 1'b1);
        chk("R5", "code 6 down above", ref_out[0], 1'b0);
        wr(2'b00, 32'h70); set_cnt(99, 1'b0);
        chk("R5", "code 7 up below", ref_out[0], 1'b0);
    endtask

    task automatic t_opm();
        wr(2'b00, 32'h10000); set_cnt(5, 1'b0);
        chk("R6", "code 8 idle up", ref_out[0], 1'b1);
        strobe_trig();
        chk("R6", "code 8 trigger holds low", ref_out[0], 1'b0);
        repeat (5) @(negedge clk);
        chk("R6", "code 8 still held", ref_out[0], 1'b0);
        strobe_upd();
        chk("R6", "code 8 update releases", ref_out[0], 1'b1);
        set_cnt(5, 1'b1);
        chk("R6", "code 8 idle down", ref_out[0], 1'b0);
        wr(2'b00, 32'h10010); set_cnt(5, 1'b0);
        chk("R6", "code 9 idle up", ref_out[0], 1'b0);
        strobe_trig();
        chk("R6", "code 9 trigger holds high", ref_out[0], 1'b1);
        strobe_upd();
        chk("R6", "code 9 update releases", ref_out[0], 1'b0);
    endtask

    task automatic t_preload();
        wr(2'b10, 32'h68); set_cnt(5, 1'b0);
        chk("R9", "preload start low", ref_out[1], 1'b0);
        wr(2'b11, 32'd10); settle();
        chk("R9", "shadow write not applied", ref_out[1], 1'b0);
        strobe_upd();
        chk("R9", "update copies shadow", ref_out[1], 1'b1);
        wr(2'b10, 32'h60); wr(2'b11, 32'd3); settle();
        chk("R9", "direct write immediate", ref_out[1], 1'b0);
    endtask

    task automatic t_combined();
        wr(2'b11, 32'd10); wr(2'b10, 32'h60); wr(2'b00, 32'h10040);
        set_cnt(50, 1'b0);
        chk("R7", "OR one high", comb_out, 1'b1);
        set_cnt(200, 1'b0);
        chk("R7", "OR none high", comb_out, 1'b0);
        wr(2'b00, 32'h10050); wr(2'b10, 32'h70); settle();
        chk("R7", "AND both high", comb_out, 1'b1);
        set_cnt(50, 1'b0);
        chk("R7", "AND one low", comb_out, 1'b0);
    endtask

    task automatic t_asym();
        wr(2'b00, 32'h10060); wr(2'b10, 32'h60); set_cnt(50, 1'b0);
        chk("R8", "up takes ch0", comb_out, 1'b1);
        set_cnt(50, 1'b1);
        chk("R8", "down ch0 level", ref_out[0], 1'b1);
        chk("R8", "down takes ch1", comb_out, 1'b0);
        set_cnt(5, 1'b1);
        chk("R8", "down ch1 high", comb_out, 1'b1);
    endtask

    task automatic t_sel();
        wr(2'b00, 32'h40); settle();
        wr(2'b00, 32'h51); set_cnt(20, 1'b0);
        chk("R10", "select non-zero ignores mode", ref_out[0], 1'b0);
        wr(2'b00, 32'h54); settle();
        chk("R10", "fast bit no effect", ref_out[0], 1'b1);
    endtask

    initial begin : wd
        repeat (WD) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cnt_in = '0; cnt_down = 1'b0; upd_evt = 1'b0;
        trig_evt = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_force();
        t_frozen();
        t_match();
        t_pwm();
        t_opm();
        t_preload();
        t_combined();
        t_asym();
        t_sel();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule